// File: doc/BRIEF.md
# Bit-Granular TDM Router with Clock Stealing

This block sits between a serial time-division-multiplexed line and a set of serial controllers. A bit counter follows the position of each line bit inside the frame, and a frame-sync strobe resets that counter. A routing table holds one destination code per bit position. It sends each received bit to exactly one destination, or to none when the bit is masked. Destinations are a set of serial controllers plus auxiliary channels, and all of them are handled the same way. Every destination gets its own data bit and its own clock pulse. A destination sees a pulse only for the bits that belong to it. Removing the pulses for foreign and masked bits lowers the effective clock rate of each controller to the rate of its own logical stream. This allows rate adaption down to single-bit granularity.

The transmit direction uses the same table. At every line bit, the owning destination supplies the outgoing bit and receives a pulse that marks it as consumed. Positions that no destination owns send a constant one. The table is written through a small register port. A write loads either one bit position or all eight positions of a timeslot, so whole-byte channels such as a selected line-card channel take one write.

Top module: `tdm_bit_router`

## Requirements
- R1: After reset every table entry is 0 (masked), all destination clock pulses are low, all receive data outputs are 0, and `tx_line` is 1.
- R2: A line bit strobed with `fsync` high is frame position 0. Every other strobe takes the next position, and position FRAME_BITS-1 is followed by 0.
- R3: A strobe at a position whose code c is in 1..NUM_DEST gives, in the next cycle, a one-cycle pulse on bit c-1 of both `rx_port_clk` and `tx_port_clk` and on no other bit. It also gives `rx_port_data[c-1]` equal to the strobed `rx_data`.
- R4: A strobe at a position whose code is 0, or greater than NUM_DEST, gives no pulse on any destination in either direction.
- R5: `rx_port_data[p]` changes only in a cycle in which `rx_port_clk[p]` pulses.
- R6: Over one frame, the number of pulses that destination p receives equals the number of table entries holding code p+1.
- R7: On a routed strobe with code c, `tx_line` in the next cycle equals `tx_port_data[c-1]` as it was at the strobe.
- R8: On a strobe at a masked or unowned position, `tx_line` in the next cycle is 1.
- R9: A write with `cfg_byte` high stores `cfg_code` in all eight positions whose index shares `cfg_addr[POS_W-1:3]` (one timeslot). It leaves all other entries as they were.
- R10: A write with `cfg_byte` low stores `cfg_code` only at position `cfg_addr`. The new entry applies from the next cycle.
- R11: In a cycle without a strobe, the next cycle shows no pulses and `tx_line` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One line bit is present in this cycle |
| fsync | input | 1 | With `bit_stb`: this bit is frame position 0 |
| rx_data | input | 1 | Received line bit |
| rx_port_clk | output | NUM_DEST | Per-destination receive clock pulse |
| rx_port_data | output | NUM_DEST | Per-destination receive data, held between pulses |
| tx_port_data | input | NUM_DEST | Per-destination bit offered for transmission |
| tx_port_clk | output | NUM_DEST | Per-destination pulse: offered bit consumed |
| tx_line | output | 1 | Merged transmit line bit |
| cfg_we | input | 1 | Table write strobe |
| cfg_byte | input | 1 | Write the whole timeslot of `cfg_addr` |
| cfg_addr | input | $clog2(FRAME_BITS) | Table position |
| cfg_code | input | $clog2(NUM_DEST+1) | Destination code, 0 masks |

## Verification
The hardest condition to reach from the ports is a frame where every code appears, including the unowned code 7, in an irregular order. In that frame the pulse count per destination must still match the table, and the held receive data must not change under foreign bits. The bench loads a code that is computed arithmetically for each position, overwrites some timeslots with byte writes, and sweeps whole frames while keeping a model of the expected per-destination data. The frame is also broken by a mid-frame sync and by a run past the frame end without sync, so that the position counter reaches both its reset and its wrap paths.

// File: rtl/tdm_router_pkg.sv
package tdm_router_pkg;

  // Next frame position, wrapping at the frame length.
  function automatic int unsigned wrap_inc(input int unsigned pos, input int unsigned frame_bits);
    return (pos + 1 >= frame_bits) ? 0 : pos + 1;
  endfunction

  // True when a destination code names destination index idx.
  function automatic bit code_hits(input int unsigned code, input int unsigned idx);
    return code == idx + 1;
  endfunction

  // Timeslot number of a bit position.
  function automatic int unsigned slot_of(input int unsigned pos);
    return pos >> 3;
  endfunction

endpackage

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter
  import tdm_router_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             fsync,
  output logic [POS_W-1:0] cur_pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] last_pos;

  assign cur_pos = fsync ? '0 : POS_W'(wrap_inc(32'(last_pos), FRAME_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) last_pos <= LAST;
    else if (bit_stb) last_pos <= cur_pos;
  end

  a_r2_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && fsync |=> last_pos == '0);
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && !fsync && last_pos == LAST |=> last_pos == '0);
  a_r11_hold_pos: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(last_pos));
endmodule

// File: rtl/tdm_route_table.sv
module tdm_route_table
  import tdm_router_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int CODE_W = 3,
  parameter int POS_W = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_byte,
  input  logic [POS_W-1:0]  cfg_addr,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [POS_W-1:0]  rd_pos,
  output logic [CODE_W-1:0] rd_code
);
  logic [CODE_W-1:0] entry [FRAME_BITS];
  logic [FRAME_BITS-1:0] wr_hit;

  for (genvar e = 0; e < FRAME_BITS; e++) begin : g_entry
    localparam logic [POS_W-1:0] EPOS = POS_W'(e);
    localparam logic [POS_W-4:0] ESLOT = (POS_W-3)'(slot_of(e));

    assign wr_hit[e] = cfg_we &&
      (cfg_byte ? (cfg_addr[POS_W-1:3] == ESLOT) : (cfg_addr == EPOS));

    always_ff @(posedge clk) begin
      if (!rst_n) entry[e] <= '0;
      else if (wr_hit[e]) entry[e] <= cfg_code;
    end
  end

  assign rd_code = entry[rd_pos];

  a_r10_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_byte |=> entry[$past(cfg_addr)] == $past(cfg_code));
  a_r9_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_byte |=> entry[{$past(cfg_addr[POS_W-1:3]), 3'b111}] == $past(cfg_code));
  a_r9_slot_size: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_byte |-> $countones(wr_hit) == 8);
endmodule

// File: rtl/tdm_rx_demux.sv
module tdm_rx_demux
  import tdm_router_pkg::*;
#(
  parameter int NUM_DEST = 6,
  parameter int CODE_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic [CODE_W-1:0]   code,
  input  logic                rx_data,
  output logic [NUM_DEST-1:0] rx_port_clk,
  output logic [NUM_DEST-1:0] rx_port_data
);
  logic [NUM_DEST-1:0] take;

  for (genvar p = 0; p < NUM_DEST; p++) begin : g_port
    assign take[p] = bit_stb && code_hits(32'(code), p);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx_port_clk[p]  <= 1'b0;
        rx_port_data[p] <= 1'b0;
      end else begin
        rx_port_clk[p] <= take[p];
        if (take[p]) rx_port_data[p] <= rx_data;
      end
    end

    a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_port_clk[p] |-> $stable(rx_port_data[p]));
  end

  a_r3_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_port_clk));
endmodule

// File: rtl/tdm_tx_merge.sv
module tdm_tx_merge
  import tdm_router_pkg::*;
#(
  parameter int NUM_DEST = 6,
  parameter int CODE_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic [CODE_W-1:0]   code,
  input  logic [NUM_DEST-1:0] tx_port_data,
  output logic [NUM_DEST-1:0] tx_port_clk,
  output logic                tx_line,
  output logic                bit_done
);
  logic [NUM_DEST-1:0] owner;
  logic                merged;

  for (genvar p = 0; p < NUM_DEST; p++) begin : g_own
    assign owner[p] = code_hits(32'(code), p);
  end

  // Unowned or masked positions idle at one.
  assign merged = (owner == '0) ? 1'b1 : |(owner & tx_port_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_port_clk <= '0;
      tx_line     <= 1'b1;
      bit_done    <= 1'b0;
    end else begin
      bit_done    <= bit_stb;
      tx_port_clk <= bit_stb ? owner : '0;
      if (bit_stb) tx_line <= merged;
    end
  end

  a_r8_idle_one: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done && tx_port_clk == '0 |-> tx_line);
  a_r11_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_done |-> $stable(tx_line));
endmodule

// File: rtl/tdm_bit_router.sv
module tdm_bit_router
  import tdm_router_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int NUM_DEST = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  bit_stb,
  input  logic                                  fsync,
  input  logic                                  rx_data,
  output logic [NUM_DEST-1:0]                   rx_port_clk,
  output logic [NUM_DEST-1:0]                   rx_port_data,
  input  logic [NUM_DEST-1:0]                   tx_port_data,
  output logic [NUM_DEST-1:0]                   tx_port_clk,
  output logic                                  tx_line,
  input  logic                                  cfg_we,
  input  logic                                  cfg_byte,
  input  logic [$clog2(FRAME_BITS)-1:0]         cfg_addr,
  input  logic [$clog2(NUM_DEST+1)-1:0]         cfg_code
);
  localparam int POS_W  = $clog2(FRAME_BITS);
  localparam int CODE_W = $clog2(NUM_DEST + 1);

  // Named internal events for the checks below.
  logic [POS_W-1:0]  cur_pos;
  logic [CODE_W-1:0] cur_code;
  logic              cur_routed;
  logic              bit_done;

  tdm_pos_counter #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fsync(fsync), .cur_pos(cur_pos)
  );

  tdm_route_table #(.FRAME_BITS(FRAME_BITS), .CODE_W(CODE_W), .POS_W(POS_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_byte(cfg_byte),
    .cfg_addr(cfg_addr), .cfg_code(cfg_code), .rd_pos(cur_pos), .rd_code(cur_code)
  );

  assign cur_routed = (cur_code != '0) && (32'(cur_code) <= NUM_DEST);

  tdm_rx_demux #(.NUM_DEST(NUM_DEST), .CODE_W(CODE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .code(cur_code), .rx_data(rx_data),
    .rx_port_clk(rx_port_clk), .rx_port_data(rx_port_data)
  );

  tdm_tx_merge #(.NUM_DEST(NUM_DEST), .CODE_W(CODE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .code(cur_code),
    .tx_port_data(tx_port_data), .tx_port_clk(tx_port_clk), .tx_line(tx_line),
    .bit_done(bit_done)
  );

  a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && !cur_routed |=> rx_port_clk == '0 && tx_port_clk == '0);
  a_r3_routed_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && cur_routed |=> $countones(rx_port_clk) == 1);
  a_r3_dirs_agree: assert property (@(posedge clk) disable iff (!rst_n)
    rx_port_clk == tx_port_clk);
  a_r11_no_stb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> rx_port_clk == '0 && !bit_done);
endmodule

// File: tb/test_tdm_bit_router.sv
`timescale 1ns/1ps
module test_tdm_bit_router;
  localparam int FB = 256;
  localparam int ND = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, fsync = 1'b0, rx_data = 1'b0;
  logic [ND-1:0] rx_port_clk, rx_port_data, tx_port_clk;
  logic [ND-1:0] tx_port_data = '0;
  logic tx_line;
  logic cfg_we = 1'b0, cfg_byte = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [2:0] cfg_code = '0;

  always #5 clk = ~clk;

  tdm_bit_router #(.FRAME_BITS(FB), .NUM_DEST(ND)) i_tdm_bit_router (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fsync(fsync), .rx_data(rx_data),
    .rx_port_clk(rx_port_clk), .rx_port_data(rx_port_data),
    .tx_port_data(tx_port_data), .tx_port_clk(tx_port_clk), .tx_line(tx_line),
    .cfg_we(cfg_we), .cfg_byte(cfg_byte), .cfg_addr(cfg_addr), .cfg_code(cfg_code)
  );

  int vectors = 0, errors = 0;
  int tbl [FB];
  int mpos = FB - 1;
  logic [ND-1:0] exp_data = '0;
  int pulses [ND];
  int serial = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit whole, input int addr, input int code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_byte = whole; cfg_addr = 8'(addr); cfg_code = 3'(code);
    @(negedge clk);
    cfg_we = 1'b0; cfg_byte = 1'b0;
    if (whole) for (int i = 0; i < 8; i++) tbl[(addr & ~7) + i] = code;
    else tbl[addr] = code;
  endtask

  // One strobed line bit, then a check half a cycle after the capturing edge.
  task automatic line_bit(input bit fs);
    int c;
    logic d;
    logic [ND-1:0] tv, exp_clk;
    logic exp_line;
    mpos = fs ? 0 : (mpos + 1) % FB;
    c = tbl[mpos];
    serial++;
    d = 1'((serial * 7 + mpos) >> 2);
    tv = ND'(serial * 37 + mpos * 11);
    exp_clk = (c >= 1 && c <= ND) ? ND'(1 << (c - 1)) : '0;
    exp_line = (c >= 1 && c <= ND) ? tv[c-1] : 1'b1;
    if (c >= 1 && c <= ND) exp_data[c-1] = d;
    @(negedge clk);
    bit_stb = 1'b1; fsync = fs; rx_data = d; tx_port_data = tv;
    @(negedge clk);
    bit_stb = 1'b0; fsync = 1'b0;
    // R3 R4 pulses in both directions
    check(rx_port_clk == exp_clk && tx_port_clk == exp_clk, "R3/R4 pulses",
          {rx_port_clk, tx_port_clk}, {exp_clk, exp_clk});
    // R3 R5 held receive data
    check(rx_port_data == exp_data, "R5 rx data", rx_port_data, exp_data);
    // R7 R8 transmit merge
    check(tx_line == exp_line, (exp_clk == 0) ? "R8 idle one" : "R7 merge", tx_line, exp_line);
    for (int p = 0; p < ND; p++) pulses[p] += rx_port_clk[p];
  endtask

  task automatic idle_check();
    logic held;
    held = tx_line;
    @(negedge clk);
    check(rx_port_clk == 0 && tx_port_clk == 0 && tx_line == held, "R11 no strobe",
          {rx_port_clk, tx_line}, {6'd0, held});
  endtask

  // R6: one full frame from sync, pulse count against table population.
  task automatic frame_run(input int gap_every);
    for (int p = 0; p < ND; p++) pulses[p] = 0;
    for (int k = 0; k < FB; k++) begin
      line_bit(k == 0);
      if (gap_every > 0 && k % gap_every == 0) idle_check();
    end
    for (int p = 0; p < ND; p++) begin
      int n = 0;
      for (int k = 0; k < FB; k++) if (tbl[k] == p + 1) n++;
      check(pulses[p] == n, "R6 pulse count", pulses[p], n);
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < FB; k++) tbl[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rx_port_clk == 0 && tx_port_clk == 0 && rx_port_data == 0 && tx_line == 1,
          "R1 reset", {rx_port_clk, tx_port_clk, rx_port_data, tx_line}, 1);
    // R1 table masked after reset: a frame gives nothing
    frame_run(0);
    // R10 per-bit programming, all codes including unowned 7
    for (int k = 0; k < FB; k++) wr(1'b0, k, (k * 5 + 3) % 8);
    frame_run(13);
    frame_run(0);
    // R9 timeslot writes
    wr(1'b1, 19, 4);
    wr(1'b1, 42, 0);
    wr(1'b1, 255, 6);
    frame_run(29);
    // R2 mid-frame sync
    for (int k = 0; k < 40; k++) line_bit(k == 0);
    line_bit(1'b1);
    // R2 wrap past frame end with no sync
    for (int k = 0; k < FB + 20; k++) line_bit(1'b0);
    // R10 single rewrite applies on the next bit
    wr(1'b0, 0, 2);
    line_bit(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule